// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial memory with 1024 bytes. A fast system clock samples the serial clock and data lines. The block finds start and stop conditions and takes in a device byte. That byte carries a fixed code, a chip-select bit checked against a strapped pin, and the two upper bits of the memory address. The block acknowledges by asking the board to pull the data line low. The open-drain wire itself sits outside the block: the output `sda_pull_o` set to 1 means "drive SDA low".

A protocol engine handles byte writes, page writes, current-address reads, random reads and sequential reads. It feeds an address counter and a write-cycle controller. The write-cycle controller gathers the bytes of one page in a buffer. A stop commits them to the array during a timed write cycle. While that cycle runs, the engine ignores its own address, so the master can poll for completion.

Top module: `twi_eeprom_engine`

## Requirements
- R1: A fall of SDA while SCL is high (start) abandons any transfer in progress and begins a fresh device-byte reception from bit zero. A rise of SDA while SCL is high (stop) returns the engine to idle. After reset, `sda_pull_o` is 0.
- R2: The device byte is received MSB first. Bits 7:4 must be 1010 and bit 3 must equal `dev_sel_i`. Bits 2:1 are address bits 9:8. Bit 0 = 1 requests a read and bit 0 = 0 requests a write. The byte is acknowledged only when bits 7:3 match and no write cycle is running.
- R3: When the device byte does not match, the engine gives no acknowledge. It then keeps SDA released for every later clock until the next start.
- R4: For each accepted byte, `sda_pull_o` is 1 for the whole ninth SCL clock. It rises after the SCL fall that follows the eighth rising edge and drops after the next SCL fall.
- R5: In a write, the byte after the device byte gives address bits 7:0. Each data byte is stored at the current address. Then bits 3:0 of the address increase modulo 16 while bits 9:4 stay fixed. A seventeenth byte or later overwrites earlier bytes of the same transfer.
- R6: Written data reaches the array only when a stop closes the write. A start seen before that stop discards the buffered bytes, and no write cycle begins.
- R7: A stop that closes a write holding at least one data byte starts a write cycle of `WR_CYCLES` clocks. During the cycle, no device byte is acknowledged. After it ends, device bytes are acknowledged again.
- R8: A read header sends bytes starting from the internal address, which is the last accessed address plus one. Each byte sent advances all 10 bits, so 0x3FF wraps to 0x000. Bits 2:1 of a read header do not change the address.
- R9: A random read is a write header plus an address byte, a repeated start and a read header. It returns the data at the address just loaded.
- R10: The engine keeps sending consecutive bytes while the master drives SDA low in the ninth clock. A master not-acknowledge ends the read, and the engine drives nothing more until the next start.
- R11: Output bits and acknowledges change only while SCL is low. Input bits are taken on the rising SCL edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Resolved serial data line level |
| dev_sel_i | input | 1 | Strapped chip-select level compared with device byte bit 3 |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge or a 0 data bit) |

## Verification
The assertions watch these rules on every cycle:
- the pull output never rises while a write cycle is running;
- the pull level holds through an acknowledge phase;
- a start zeroes the bit count;
- address increments stay inside the page or wrap at the array top;
- a discard empties the page buffer and a commit raises busy.

Other behaviour shows only in the bench's transfers:
- the stored contents after page rollover;
- aborted writes leaving memory untouched;
- polled acknowledges during a write cycle;
- random, current and sequential reads returning the right bytes;
- silence after an address mismatch or a master not-acknowledge.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_ADDR,
    S_WR,
    S_ACK,
    S_TX,
    S_MACK
  } eng_st_t;
endpackage

// File: rtl/line_mon.sv
module line_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;

  // Both lines idle high, so the synchronizers reset to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_q  <= scl_sy[SYNC-1];
      sda_q  <= sda_sy[SYNC-1];
    end
  end

  assign scl_lvl  = scl_sy[SYNC-1];
  assign sda_lvl  = sda_sy[SYNC-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/addr_ctr.sv
module addr_ctr #(
  parameter int AW = 10,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_page,
  input  logic          inc_all,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)          ptr_d = load_val;
    else if (inc_all)  ptr_d = ptr_q + 1'b1;
    else if (inc_page) ptr_d = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R5: a write increment stays inside the current page.
  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_page && !load |=> ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW]));
  // R8: a read increment wraps from the top of the array to zero.
  p_full_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inc_all && !load && (ptr_q == '1) |=> ptr_q == '0);
endmodule

// File: rtl/wr_ctl.sv
module wr_ctl #(
  parameter int AW        = 10,
  parameter int PW        = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [7:0]    push_data,
  input  logic          discard,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy
);
  localparam int PAGE  = 1 << PW;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(WR_CYCLES);

  logic [7:0]       arr_q [DEPTH];
  logic [7:0]       buf_q [PAGE];
  logic [PAGE-1:0]  mask_q, mask_d;
  logic [AW-PW-1:0] page_q, page_d;
  logic             busy_q, busy_d;
  logic [CW-1:0]    tmr_q, tmr_d;
  logic             wr_en;
  logic [AW-1:0]    wr_idx;

  assign wr_idx = {page_q, tmr_q[PW-1:0]};

  always_comb begin
    mask_d = mask_q;
    page_d = page_q;
    busy_d = busy_q;
    tmr_d  = tmr_q;
    wr_en  = 1'b0;
    if (busy_q) begin
      tmr_d = tmr_q + 1'b1;
      if (tmr_q < CW'(PAGE) && mask_q[tmr_q[PW-1:0]]) begin
        wr_en = 1'b1;
        mask_d[tmr_q[PW-1:0]] = 1'b0;
      end
      if (tmr_q == CW'(WR_CYCLES - 1)) busy_d = 1'b0;
    end else if (discard) begin
      mask_d = '0;
    end else if (push) begin
      mask_d[push_addr[PW-1:0]] = 1'b1;
      page_d = push_addr[AW-1:PW];
    end else if (commit && |mask_q) begin
      busy_d = 1'b1;
      tmr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      page_q <= '0;
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      page_q <= page_d;
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !busy_q) buf_q[push_addr[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en) arr_q[wr_idx] <= buf_q[tmr_q[PW-1:0]];
  end

  assign rd_data = arr_q[rd_addr];
  assign busy    = busy_q;

  // R6: a start outside a write cycle leaves nothing to commit.
  p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    discard && !busy_q |=> mask_q == '0);
  // R7: a stop with buffered bytes opens a write cycle.
  p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !busy_q && !discard && (mask_q != '0) |=> busy_q);
endmodule

// File: rtl/eep_engine.sv
module eep_engine
  import eep_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sel_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_load_val,
  output logic          ptr_inc_page,
  output logic          ptr_inc_all,
  output logic          push,
  output logic [7:0]    push_data,
  output logic          discard,
  output logic          commit,
  output logic          sda_pull
);
  localparam int HW = AW - 8;

  eng_st_t       st_q, st_d, after_q, after_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic [HW-1:0] hi_q, hi_d;
  logic          mack_q, mack_d;
  logic          pull_q, pull_d;

  always_comb begin
    st_d = st_q; after_d = after_q; cnt_d = cnt_q; sh_d = sh_q;
    hi_d = hi_q; mack_d = mack_q; pull_d = pull_q;
    ptr_load = 1'b0; ptr_load_val = {hi_q, sh_q};
    ptr_inc_page = 1'b0; ptr_inc_all = 1'b0;
    push = 1'b0; push_data = sh_q; discard = 1'b0; commit = 1'b0;
    if (start_ev) begin
      st_d = S_DEV; cnt_d = '0; pull_d = 1'b0; discard = 1'b1;
    end else if (stop_ev) begin
      st_d = S_IDLE; cnt_d = '0; pull_d = 1'b0; commit = 1'b1;
    end else begin
      case (st_q)
        S_DEV, S_ADDR, S_WR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0;
            if (st_q == S_DEV) begin
              if (sh_q[7:4] == DEV_CODE && sh_q[3] == sel_i && !busy_i) begin
                pull_d  = 1'b1;
                st_d    = S_ACK;
                hi_d    = sh_q[HW:1];
                after_d = sh_q[0] ? S_TX : S_ADDR;
              end else begin
                st_d = S_IDLE;
              end
            end else if (st_q == S_ADDR) begin
              ptr_load = 1'b1;
              pull_d   = 1'b1;
              st_d     = S_ACK;
              after_d  = S_WR;
            end else begin
              push         = 1'b1;
              ptr_inc_page = 1'b1;
              pull_d       = 1'b1;
              st_d         = S_ACK;
              after_d      = S_WR;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            if (after_q == S_TX) begin
              sh_d        = {rd_data[6:0], 1'b0};
              pull_d      = ~rd_data[7];
              ptr_inc_all = 1'b1;
            end
            st_d = after_q;
          end
        end
        S_TX: begin
          if (scl_rise && cnt_q < 4'd8) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            st_d   = S_MACK;
          end else if (scl_fall && cnt_q != 4'd0) begin
            pull_d = ~sh_q[7];
            sh_d   = {sh_q[6:0], 1'b0};
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d        = {rd_data[6:0], 1'b0};
              pull_d      = ~rd_data[7];
              ptr_inc_all = 1'b1;
              st_d        = S_TX;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; after_q <= S_IDLE; cnt_q <= '0; sh_q <= '0;
      hi_q <= '0; mack_q <= 1'b0; pull_q <= 1'b0;
    end else begin
      st_q <= st_d; after_q <= after_d; cnt_q <= cnt_d; sh_q <= sh_d;
      hi_q <= hi_d; mack_q <= mack_d; pull_q <= pull_d;
    end
  end

  assign sda_pull = pull_q;

  // R1: a start always restarts header reception from bit zero.
  p_start_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> st_q == S_DEV && cnt_q == 4'd0);
  // R7: no acknowledge or data is driven while a write cycle runs.
  p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !$past(busy_i));
  // R4: the pull level holds for the whole acknowledge phase.
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_ACK && $past(st_q) == S_ACK |-> $stable(pull_q));
  // R11: the line driver moves only while SCL is low.
  p_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) && !$past(start_ev) && !$past(stop_ev) |-> !$past(scl_lvl));
endmodule

// File: rtl/twi_eeprom_engine.sv
module twi_eeprom_engine #(
  parameter int AW        = 10,
  parameter int PW        = 4,
  parameter int WR_CYCLES = 1000,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic dev_sel_i,
  output logic sda_pull_o
);
  logic [1:0]    rst_sy;
  logic          rst_ns;
  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic          ptr_load, ptr_inc_page, ptr_inc_all;
  logic [AW-1:0] ptr_load_val, ptr;
  logic          push, discard, commit, busy;
  logic [7:0]    push_data, rd_data;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sy <= 2'b00;
    else        rst_sy <= {rst_sy[0], 1'b1};
  end
  assign rst_ns = rst_sy[1];

  line_mon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst_n(rst_ns), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_ns), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .sel_i(dev_sel_i), .busy_i(busy), .rd_data(rd_data),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .ptr_inc_page(ptr_inc_page), .ptr_inc_all(ptr_inc_all),
    .push(push), .push_data(push_data), .discard(discard),
    .commit(commit), .sda_pull(sda_pull_o)
  );

  addr_ctr #(.AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_ns), .load(ptr_load), .load_val(ptr_load_val),
    .inc_page(ptr_inc_page), .inc_all(ptr_inc_all), .ptr(ptr)
  );

  wr_ctl #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_wr (
    .clk(clk), .rst_n(rst_ns), .push(push), .push_addr(ptr),
    .push_data(push_data), .discard(discard), .commit(commit),
    .rd_addr(ptr), .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: tb/sim_twi_eeprom_engine.sv
`timescale 1ns/1ps
module sim_twi_eeprom_engine;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic sda_line;
  int   n_chk = 0;
  int   n_fail = 0;

  logic [7:0] model [1024];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_b;
  event       got_ev;
  logic       watch = 1'b0;
  logic       pull_seen = 1'b0;
  logic       prev_pull = 1'b0;
  int         r11_viol = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  twi_eeprom_engine #(.WR_CYCLES(1000)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_sel_i(1'b1), .sda_pull_o(sda_pull)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor side of the scoreboard: compares each byte as it arrives.
  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", got_b, 0);
    else chk(got_b == exp_q[0], tag_q[0], got_b, exp_q[0]);
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
  end

  always @(negedge clk) begin
    if (watch && sda_pull) pull_seen <= 1'b1;
    if (rst_n && sda_pull !== prev_pull && scl) r11_viol++;
    prev_pull <= sda_pull;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask
  task automatic bus_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask
  task automatic put_bit(input logic b);
    m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask
  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask
  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask
  task automatic get_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~mack);
  endtask

  function automatic logic [7:0] hdr(input int a, input logic rd);
    hdr = {4'b1010, 1'b1, a[9], a[8], rd};
  endfunction

  // Driver side: pushes the expected bytes, then clocks them out.
  task automatic rd_seq(input int a, input int n, input string tag);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(a + i) % 1024]);
      tag_q.push_back(tag);
      get_byte(v, i < n - 1);
      got_b = v;
      ->got_ev;
    end
  endtask

  task automatic wait_ready(input string tag);
    logic ack;
    bit   done = 1'b0;
    bus_start(); put_byte(hdr(0, 1'b0), ack); bus_stop();
    chk(!ack, {tag, " R7 poll nacked during write cycle"}, ack, 0);
    for (int k = 0; k < 10 && !done; k++) begin
      bus_start(); put_byte(hdr(0, 1'b0), ack); bus_stop();
      done = ack;
    end
    chk(done, {tag, " R7 poll acked after write cycle"}, done, 1);
  endtask

  task automatic do_write(input int a, input int n, input int base, input string tag);
    logic ack;
    int   off = a % 16;
    bus_start();
    put_byte(hdr(a, 1'b0), ack); chk(ack, {tag, " R2 write header ack"}, ack, 1);
    put_byte(a[7:0], ack);       chk(ack, {tag, " R4 address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(8'(base + i), ack);
      chk(ack, {tag, " R4 data ack"}, ack, 1);
      model[(a / 16) * 16 + off] = 8'(base + i);
      off = (off + 1) % 16;
    end
    bus_stop();
    wait_ready(tag);
  endtask

  task automatic rand_read(input int a, input int n, input string tag, input bit do_stop);
    logic ack;
    bus_start();
    put_byte(hdr(a, 1'b0), ack); chk(ack, {tag, " R9 dummy write ack"}, ack, 1);
    put_byte(a[7:0], ack);       chk(ack, {tag, " R9 address ack"}, ack, 1);
    bus_start();
    put_byte(hdr(a, 1'b1), ack); chk(ack, {tag, " R9 read header ack"}, ack, 1);
    rd_seq(a, n, tag);
    if (do_stop) bus_stop();
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 1024; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 line released in reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R1 line released after reset", sda_pull, 0);

    // Page write crossing the page end: wraps to the page start.
    do_write(10'h2FA, 8, 8'h11, "R5 page wrap write");
    rand_read(10'h2FA, 6, "R9 random read", 1'b1);
    rand_read(10'h2F0, 1, "R5 wrapped bytes", 1'b1);

    // Current address read with header bits 2:1 unrelated to the pointer.
    bus_start();
    put_byte(hdr(0, 1'b1), ack); chk(ack, "R8 current read header ack", ack, 1);
    rd_seq(10'h2F1, 1, "R8 current address read");
    bus_stop();

    // Eighteen bytes into one page: the last two overwrite the first two.
    do_write(10'h105, 18, 8'h40, "R5 overwrite");
    rand_read(10'h100, 16, "R10 sequential read", 1'b1);

    // Read wrap at the top of the array.
    do_write(10'h3FF, 1, 8'h77, "R5 top byte");
    do_write(10'h000, 1, 8'h66, "R5 bottom byte");
    rand_read(10'h3FF, 2, "R8 read wrap", 1'b1);

    // A start before the stop aborts the write.
    do_write(10'h120, 1, 8'h5A, "R6 setup");
    bus_start();
    put_byte(hdr(10'h120, 1'b0), ack);
    put_byte(8'h20, ack);
    put_byte(8'hEE, ack); chk(ack, "R6 aborted byte ack", ack, 1);
    bus_start();
    bus_stop();
    bus_start();
    put_byte(hdr(0, 1'b0), ack); chk(ack, "R6 no write cycle after abort", ack, 1);
    bus_stop();
    rand_read(10'h120, 1, "R6 memory kept", 1'b1);

    // Chip-select mismatch: no ack and silence until the next start.
    bus_start();
    put_byte(8'hA1, ack); chk(!ack, "R3 select mismatch nack", ack, 0);
    pull_seen = 1'b0; watch = 1'b1;
    put_byte(8'hA8, ack);
    watch = 1'b0;
    chk(!pull_seen, "R3 silent after mismatch", pull_seen, 0);
    bus_stop();

    // Wrong device code.
    bus_start();
    put_byte(8'h58, ack); chk(!ack, "R2 wrong code nack", ack, 0);
    bus_stop();

    // A start in the middle of a byte restarts header reception.
    bus_start();
    put_byte(hdr(10'h120, 1'b0), ack);
    put_byte(8'h20, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    put_byte(hdr(10'h120, 1'b1), ack); chk(ack, "R1 header after mid-byte start", ack, 1);
    rd_seq(10'h120, 1, "R1 read after restart");
    bus_stop();

    // A master not-acknowledge ends the read.
    rand_read(10'h120, 1, "R10 single read", 1'b0);
    pull_seen = 1'b0; watch = 1'b1;
    put_byte(8'hFF, ack);
    watch = 1'b0;
    chk(!pull_seen, "R10 silent after master nack", pull_seen, 0);
    bus_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    chk(r11_viol == 0, "R11 pull changed with SCL high", r11_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule